// File: doc/BRIEF.md
# Trigger-Latched Programmable Delay Pulser

This block is a clocked delay generator. On a qualified rising edge of its trigger input it captures an 8-bit delay code in the same clock and starts a delay cycle. Once a fixed minimum latency plus a number of clock ticks equal to the code has passed, it drives one output pulse of fixed width. The end of that pulse returns the block to idle, ready for the next trigger.

The trigger is qualified by an active-low enable that is looked at only in the cycle of the trigger edge. While a cycle is in progress a busy flag is high, and further trigger edges are dropped rather than stored. The trigger and enable are taken to be synchronous to the clock. A rising edge is detected by comparing the trigger with its value one clock earlier.

Top module: `trig_delay_pulser`

## Requirements
- R1: A delay cycle starts only in a clock where `trig_i` is 1, `trig_i` was 0 in the previous clock, `ce_n_i` is 0 and `busy_o` is 0. Holding `trig_i` high starts no further cycle.
- R2: A trigger edge seen while `ce_n_i` is 1 is ignored. `busy_o` stays 0 and no pulse follows.
- R3: `code_i` is captured in the clock that starts the cycle. Changes on `code_i` after that clock do not alter the delay of the cycle in progress.
- R4: The code is an unsigned binary number with bit 0 as the least significant bit. If the start is taken at clock edge k, `pulse_o` first reads 1 after edge k + MIN_LAT + code.
- R5: Code 0x00 gives the nonzero minimum delay of MIN_LAT clocks (default 2). Code 0xFF gives MIN_LAT + 255.
- R6: Every output pulse lasts exactly PULSE_W clocks (default 3), whatever the code.
- R7: `busy_o` is 1 from the start edge through the last pulse clock and drops together with `pulse_o`. The block accepts a trigger edge in the first clock in which `busy_o` reads 0.
- R8: A trigger edge arriving while `busy_o` is 1 is neither acted on nor queued. Exactly one pulse is produced per cycle.
- R9: While `rst_n` is low, `pulse_o` and `busy_o` are 0. After reset the block is idle and armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| trig_i | input | 1 | Trigger; its rising edge starts a cycle |
| ce_n_i | input | 1 | Active-low enable, sampled in the trigger-edge clock |
| code_i | input | 8 | Delay code, captured with the trigger |
| pulse_o | output | 1 | Output pulse, PULSE_W clocks wide |
| busy_o | output | 1 | High while a delay cycle or pulse is in progress |

## Verification
The bench builds the block with its defaults, MIN_LAT = 2 and PULSE_W = 3. A code of 0x00 then gives a 2-clock latency that is clearly different from the 3-clock latency of 0x01. Code 0xFF drives the countdown through its full 9-bit load of 256. The 3-clock pulse is long enough that a pulse cut short or stretched by one clock is seen as a width error. It also leaves room to test rearming in the first idle clock right after a pulse.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_PULSE = 2'd2
  } phase_e;
endpackage

// File: rtl/tdp_edge_qual.sv
module tdp_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic ce_n_i,
  input  logic busy_i,
  output logic start_o
);
  logic trig_q;
  logic trig_d;

  always_comb begin
    trig_d  = trig_i;
    start_o = trig_i & ~trig_q & ~ce_n_i & ~busy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end
endmodule

// File: rtl/tdp_delay_ctr.sv
module tdp_delay_ctr #(
  parameter int CODE_W  = 8,
  parameter int MIN_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              active_o,
  output logic              expire_o
);
  localparam int CNT_W = $clog2(MIN_LAT + (1 << CODE_W));

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             en;

  always_comb begin
    en       = start_i | act_q;
    cnt_d    = cnt_q;
    act_d    = act_q;
    expire_o = act_q && (cnt_q == '0);
    if (start_i) begin
      act_d = 1'b1;
      cnt_d = CNT_W'(MIN_LAT - 1) + {{(CNT_W-CODE_W){1'b0}}, code_i};
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - CNT_W'(1);
    end
    active_o = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tdp_pulse_gen.sv
module tdp_pulse_gen #(
  parameter int PULSE_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int PC_W = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

  logic [PC_W-1:0] pc_q, pc_d;
  logic            on_q, on_d;
  logic            en;

  always_comb begin
    en   = fire_i | on_q;
    pc_d = pc_q;
    on_d = on_q;
    if (fire_i) begin
      on_d = 1'b1;
      pc_d = PC_W'(PULSE_W - 1);
    end else if (on_q) begin
      if (pc_q == '0) on_d = 1'b0;
      else            pc_d = pc_q - PC_W'(1);
    end
    pulse_o = on_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      pc_q <= '0;
    end else if (en) begin
      on_q <= on_d;
      pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/trig_delay_pulser.sv
module trig_delay_pulser #(
  parameter int CODE_W  = 8,
  parameter int MIN_LAT = 2,
  parameter int PULSE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              ce_n_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o,
  output logic              busy_o
);
  import tdp_pkg::*;

  logic   start, wait_act, expire, pulse;
  phase_e phase;

  tdp_edge_qual u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig_i),
    .ce_n_i  (ce_n_i),
    .busy_i  (busy_o),
    .start_o (start)
  );

  tdp_delay_ctr #(.CODE_W(CODE_W), .MIN_LAT(MIN_LAT)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .code_i   (code_i),
    .active_o (wait_act),
    .expire_o (expire)
  );

  tdp_pulse_gen #(.PULSE_W(PULSE_W)) u_pls (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (expire),
    .pulse_o (pulse)
  );

  always_comb begin
    if (pulse)         phase = PH_PULSE;
    else if (wait_act) phase = PH_WAIT;
    else               phase = PH_IDLE;
    busy_o  = (phase != PH_IDLE);
    pulse_o = pulse;
  end
endmodule

// File: rtl/tdp_checker.sv
module tdp_checker #(
  parameter int MIN_LAT = 2,
  parameter int PULSE_W = 3
) (
  input logic clk,
  input logic rst_n,
  input logic trig_i,
  input logic ce_n_i,
  input logic pulse_o,
  input logic busy_o
);
  logic        tq, pq;
  logic [15:0] hcnt, wcnt;
  logic [1:0]  rcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tq <= 1'b0; pq <= 1'b0; hcnt <= '0; wcnt <= '0; rcnt <= '0;
    end else begin
      tq   <= trig_i;
      pq   <= pulse_o;
      hcnt <= pulse_o ? hcnt + 16'd1 : 16'd0;
      wcnt <= (busy_o && !pulse_o) ? wcnt + 16'd1 : 16'd0;
      if (!busy_o)                      rcnt <= '0;
      else if (pulse_o && !pq && rcnt != 2'd3) rcnt <= rcnt + 2'd1;
    end
  end

  a_r1_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !(trig_i && !tq)) |=> !busy_o);
  a_r2_ce_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && ce_n_i) |=> !busy_o);
  a_r5_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> (wcnt >= 16'(MIN_LAT)));
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> (hcnt == 16'(PULSE_W)));
  a_r7_pulse_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> busy_o);
  a_r7_rearm_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> !busy_o);
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (rcnt == 2'd1));
endmodule

bind trig_delay_pulser tdp_checker #(.MIN_LAT(MIN_LAT), .PULSE_W(PULSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .ce_n_i(ce_n_i),
  .pulse_o(pulse_o), .busy_o(busy_o)
);

// File: tb/test_trig_delay_pulser.sv
module test_trig_delay_pulser;
  localparam int MIN_LAT = 2;
  localparam int PULSE_W = 3;

  logic       clk, rst_n, trig_i, ce_n_i;
  logic [7:0] code_i;
  logic       pulse_o, busy_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int exp_q[$];
  int code_q[$];
  int rise_cyc;
  logic pprev = 1'b0;
  bit done = 1'b0;

  trig_delay_pulser #(.CODE_W(8), .MIN_LAT(MIN_LAT), .PULSE_W(PULSE_W)) i_trig_delay_pulser (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .ce_n_i(ce_n_i),
    .code_i(code_i), .pulse_o(pulse_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected rise times, measures width
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pulse_o && !pprev) begin
        rise_cyc = cyc;
        if (exp_q.size() == 0) begin
          check("R8 unexpected pulse at cycle", cyc, -1);
        end else begin
          int e, c;
          e = exp_q.pop_front();
          c = code_q.pop_front();
          check((c == 0) ? "R5 latency code 0" : "R4 latency", cyc, e);
        end
      end
      if (!pulse_o && pprev) begin
        check("R6 pulse width", cyc - rise_cyc, PULSE_W);
        check("R7 busy low with pulse end", int'(busy_o), 0);
      end
      pprev = pulse_o;
    end
  end

  task automatic fire(input logic [7:0] c, input logic ce, input bit expect_pulse,
                      input bit exp_busy, input bit wait_first, input string req);
    if (wait_first) @(negedge clk);
    code_i = c; ce_n_i = ce; trig_i = 1'b1;
    if (expect_pulse) begin
      exp_q.push_back(cyc + 1 + MIN_LAT + int'(c));
      code_q.push_back(int'(c));
    end
    @(negedge clk);
    trig_i = 1'b0;
    check(req, int'(busy_o), int'(exp_busy));
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy_o && exp_q.size() == 0 && !pulse_o) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b1; trig_i = 1'b0; ce_n_i = 1'b0; code_i = 8'h00;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 pulse in reset", int'(pulse_o), 0);
    check("R9 busy in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", int'(busy_o), 0);

    // R4/R5 latency sweep
    fire(8'h00, 1'b0, 1, 1, 1, "R7 busy after start"); wait_idle();
    fire(8'h01, 1'b0, 1, 1, 1, "R7 busy after start"); wait_idle();
    fire(8'h80, 1'b0, 1, 1, 1, "R7 busy after start"); wait_idle();
    fire(8'hFF, 1'b0, 1, 1, 1, "R7 busy after start"); wait_idle();
    fire(8'h5A, 1'b0, 1, 1, 1, "R7 busy after start"); wait_idle();

    // R2: enable high
    fire(8'h04, 1'b1, 0, 0, 1, "R2 ce high busy");
    repeat (MIN_LAT + 10) @(negedge clk);
    check("R2 no pulse with ce high", int'(pulse_o), 0);
    check("R2 still idle", int'(busy_o), 0);

    // R8: trigger while busy
    fire(8'h10, 1'b0, 1, 1, 1, "R7 busy after start");
    repeat (4) @(negedge clk);
    fire(8'h00, 1'b0, 0, 1, 0, "R8 busy kept on retrigger");
    wait_idle();
    check("R8 no queued cycle", int'(busy_o), 0);

    // R3: code changes after capture
    fire(8'h20, 1'b0, 1, 1, 1, "R3 busy after start");
    code_i = 8'hFF;
    repeat (3) @(negedge clk);
    code_i = 8'h00;
    wait_idle();

    // R1: trigger held high across the cycle
    @(negedge clk);
    code_i = 8'h03; ce_n_i = 1'b0; trig_i = 1'b1;
    exp_q.push_back(cyc + 1 + MIN_LAT + 3);
    code_q.push_back(3);
    wait_idle();
    repeat (8) @(negedge clk);
    check("R1 held trigger no restart", int'(busy_o), 0);
    trig_i = 1'b0;
    @(negedge clk);

    // R7: rearm in the first idle clock
    fire(8'h02, 1'b0, 1, 1, 1, "R7 busy after start");
    while (busy_o) @(negedge clk);
    fire(8'h01, 1'b0, 1, 1, 0, "R7 accepted in first idle clock");
    wait_idle();
    check("R4 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule